// File: doc/BRIEF.md
# Per-Port Power Management Controller

This block decides, for a single PHY port, whether the normal transmit and receive paths are powered. While a cable is attached the port runs normally. Once the cable has been absent for an uninterrupted timeout, the controller drops the port into a power-saving state. In that state it only asks a pulse generator for a normal link pulse at a fixed pace, and it listens to three activity detectors. Any one of them reports incoming energy and the port returns to normal operation.

A management power-down bit overrides all of this. While it is set, every transmit and receive function, link pulses included, is turned off. When it is cleared the port returns to normal and requests a fresh link establishment. Time is measured in prescaled ticks from a shared timebase (1 ms by default), so both the timeout and the link-pulse pace are tick counts held in parameters. Each port carries its own instance.

Top module: `port_pwr_mgr`

## Requirements
- R1: Out of reset the port is in the normal state: tx_en_o and rx_en_o are 1, and nlp_req_o and link_restart_o are 0.
- R2: With the cable absent and power-down clear, the port leaves the normal state exactly at the clock edge that samples the TIMEOUT_TICKS-th tick of continuous absence. tx_en_o and rx_en_o then read 0. Cycles without tick_i never advance the count.
- R3: Any cycle with link_present_i high in the normal state clears the absence count, so a full TIMEOUT_TICKS further ticks of absence are needed before saving starts.
- R4: In the saving state nlp_req_o is a one-cycle pulse. It follows every NLP_TICKS-th tick counted from entry into saving. It is never high outside the saving state.
- R5: In the saving state, any set bit of act_i wakes the port at the next edge (tx_en_o = rx_en_o = 1). The bits are: bit 0 = 100 Mb idle seen, bit 1 = 10 Mb link pulse seen, bit 2 = auto-negotiation burst seen. The following absence timeout then counts from zero.
- R6: With pwr_down_i high, from the next edge on tx_en_o, rx_en_o and nlp_req_o are all 0, whatever the state, the ticks, link_present_i or act_i.
- R7: The first edge that samples pwr_down_i low after power-down returns the port to normal. It also raises link_restart_o for exactly one cycle, and the absence timeout restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tick_i | input | 1 | One-cycle strobe from the prescaled timebase |
| link_present_i | input | 1 | High while a cable or link partner is detected |
| act_i | input | 3 | Receive activity detectors: bit 0 idle, bit 1 link pulse, bit 2 negotiation burst |
| pwr_down_i | input | 1 | Management power-down control bit |
| tx_en_o | output | 1 | Enable for the normal transmit path |
| rx_en_o | output | 1 | Enable for the normal receive path |
| nlp_req_o | output | 1 | One-cycle request to emit a normal link pulse |
| link_restart_o | output | 1 | One-cycle request to restart link establishment |

## Verification
The assertions assume that all inputs are synchronous to clk and stable around the sampling edge. They also assume that tick_i is a single-cycle strobe and that NLP_TICKS is at least 2, so link pulse requests can never fall on adjacent cycles. The bench drives every input at the falling edge and draws tick_i, the cable state, the activity bits and power-down from $urandom with a fixed seed. The cable state and power-down change rarely, so timeouts, saving entry, wakes and power-down exits all occur. Directed sequences cover the exact timeout edge, reconnection one tick short, each activity bit alone, and power-down entered from the saving state.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  typedef enum logic [1:0] {
    PM_NORMAL = 2'd0,
    PM_SAVING = 2'd1,
    PM_PDOWN  = 2'd2
  } pm_state_e;

  localparam int unsigned ACT_KINDS = 3;
  localparam int unsigned ACT_IDLE  = 0;
  localparam int unsigned ACT_NLP   = 1;
  localparam int unsigned ACT_FLP   = 2;

endpackage

// File: rtl/ppm_tick_counter.sv
// Counts timebase ticks up to LIMIT; hit_o marks the tick that completes the span.
module ppm_tick_counter #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic tick_i,
  output logic hit_o
);
  localparam int unsigned W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign hit_o  = !clr_i && tick_i && (cnt_q == LAST);
  assign cnt_en = clr_i || tick_i;

  always_comb begin
    if (clr_i || hit_o) cnt_d = '0;
    else                cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ppm_wake_detect.sv
// Merges the receive activity detectors into one wake request.
module ppm_wake_detect #(
  parameter int unsigned KINDS = ppm_pkg::ACT_KINDS
) (
  input  logic             en_i,
  input  logic [KINDS-1:0] act_i,
  output logic             wake_o
);
  logic [KINDS:0] chain;

  assign chain[0] = 1'b0;
  for (genvar g = 0; g < KINDS; g++) begin : g_merge
    assign chain[g+1] = chain[g] | act_i[g];
  end

  assign wake_o = en_i && chain[KINDS];
endmodule

// File: rtl/ppm_fsm.sv
// Power state sequencing: normal, saving and management power-down.
module ppm_fsm
  import ppm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pwr_down_i,
  input  logic      absent_done_i,
  input  logic      wake_i,
  input  logic      pace_hit_i,
  output pm_state_e state_o,
  output logic      nlp_req_o,
  output logic      restart_o
);
  pm_state_e state_q, state_d;
  logic      nlp_q, restart_q;

  always_comb begin
    state_d = state_q;
    if (pwr_down_i) begin
      state_d = PM_PDOWN;
    end else begin
      unique case (state_q)
        PM_NORMAL: if (absent_done_i) state_d = PM_SAVING;
        PM_SAVING: if (wake_i)        state_d = PM_NORMAL;
        PM_PDOWN:                     state_d = PM_NORMAL;
        default:                      state_d = PM_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= PM_NORMAL;
      nlp_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      nlp_q     <= pace_hit_i;
      restart_q <= (state_q == PM_PDOWN) && !pwr_down_i;
    end
  end

  assign state_o   = state_q;
  assign nlp_req_o = nlp_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/port_pwr_mgr.sv
// Per-port power management top: absence timer, link pulse pacer, wake merge, FSM.
module port_pwr_mgr
  import ppm_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 10000,
  parameter int unsigned NLP_TICKS     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 link_present_i,
  input  logic [ACT_KINDS-1:0] act_i,
  input  logic                 pwr_down_i,
  output logic                 tx_en_o,
  output logic                 rx_en_o,
  output logic                 nlp_req_o,
  output logic                 link_restart_o
);
  pm_state_e state;
  logic      absent_done, pace_hit, wake;
  logic      absent_clr, pace_clr;

  assign absent_clr = (state != PM_NORMAL) || link_present_i || pwr_down_i;
  assign pace_clr   = (state != PM_SAVING) || pwr_down_i || wake;

  ppm_tick_counter #(.LIMIT(TIMEOUT_TICKS)) u_absent_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (absent_clr),
    .tick_i (tick_i),
    .hit_o  (absent_done)
  );

  ppm_tick_counter #(.LIMIT(NLP_TICKS)) u_nlp_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (pace_clr),
    .tick_i (tick_i),
    .hit_o  (pace_hit)
  );

  ppm_wake_detect #(.KINDS(ACT_KINDS)) u_wake (
    .en_i   (state == PM_SAVING),
    .act_i  (act_i),
    .wake_o (wake)
  );

  ppm_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_down_i    (pwr_down_i),
    .absent_done_i (absent_done),
    .wake_i        (wake),
    .pace_hit_i    (pace_hit),
    .state_o       (state),
    .nlp_req_o     (nlp_req_o),
    .restart_o     (link_restart_o)
  );

  assign tx_en_o = (state == PM_NORMAL);
  assign rx_en_o = (state == PM_NORMAL);
endmodule

// File: rtl/ppm_checker.sv
module ppm_checker #(
  parameter int unsigned NLP_TICKS = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_i,
  input logic       link_present_i,
  input logic [2:0] act_i,
  input logic       pwr_down_i,
  input logic       tx_en_o,
  input logic       rx_en_o,
  input logic       nlp_req_o,
  input logic       link_restart_o
);
  // R2
  no_tick_no_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_o && !tick_i && !pwr_down_i) |=> (tx_en_o && rx_en_o));

  // R3
  present_keeps_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en_o && link_present_i && !pwr_down_i) |=> (tx_en_o && rx_en_o));

  // R4
  nlp_only_saving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nlp_req_o |-> (!tx_en_o && !rx_en_o));

  // R4
  nlp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nlp_req_o && (NLP_TICKS > 1)) |=> !nlp_req_o);

  // R5
  wake_on_activity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en_o && !pwr_down_i && (act_i != 3'b000)) |=> (tx_en_o && rx_en_o));

  // R6
  pdown_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |=> (!tx_en_o && !rx_en_o && !nlp_req_o));

  // R7
  restart_in_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_restart_o |-> (tx_en_o && rx_en_o && !nlp_req_o));

  // R7
  restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_restart_o |=> !link_restart_o);
endmodule

bind port_pwr_mgr ppm_checker #(.NLP_TICKS(NLP_TICKS)) u_chk (.*);

// File: tb/port_pwr_mgr_tb.sv
module port_pwr_mgr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T_TICKS    = 20;
  localparam int P_TICKS    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, link = 1'b1, pd = 1'b0;
  logic [2:0] act = 3'b000;
  logic       tx_en, rx_en, nlp_req, restart;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Behavioural model built from the requirements
  int m_state;  // 0 normal, 1 saving, 2 power-down
  int m_cnt, m_pcnt;
  bit m_nlp, m_rst;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_pwr_mgr #(.TIMEOUT_TICKS(T_TICKS), .NLP_TICKS(P_TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .link_present_i(link),
    .act_i(act), .pwr_down_i(pd), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .nlp_req_o(nlp_req), .link_restart_o(restart));

  function automatic int next_state(int s, bit tk, bit ln, logic [2:0] a, bit p, int c);
    if (p) return 2;
    if (s == 0) return (!ln && tk && c == T_TICKS-1) ? 1 : 0;
    if (s == 1) return (a != 3'b000) ? 0 : 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_cnt <= 0; m_pcnt <= 0; m_nlp <= 0; m_rst <= 0;
    end else begin
      m_nlp   <= (m_state == 1) && !pd && (act == 3'b000) && tick && (m_pcnt == P_TICKS-1);
      m_rst   <= (m_state == 2) && !pd;
      m_state <= next_state(m_state, tick, link, act, pd, m_cnt);
      if (m_state == 0 && !pd && !link)
        m_cnt <= tick ? ((m_cnt == T_TICKS-1) ? 0 : m_cnt + 1) : m_cnt;
      else
        m_cnt <= 0;
      if (m_state == 1 && !pd && act == 3'b000)
        m_pcnt <= tick ? ((m_pcnt == P_TICKS-1) ? 0 : m_pcnt + 1) : m_pcnt;
      else
        m_pcnt <= 0;
    end
  end

  task automatic chk(input logic act_v, input logic exp_v, input string what);
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", what, act_v, exp_v, $time);
    end
  endtask

  task automatic cmp_model();
    chk(tx_en,   m_state == 0, "R2 tx_en vs model");
    chk(rx_en,   m_state == 0, "R5 rx_en vs model");
    chk(nlp_req, m_nlp,        "R4 nlp_req vs model");
    chk(restart, m_rst,        "R7 link_restart vs model");
  endtask

  task automatic cyc(input bit tk, input bit ln, input logic [2:0] a, input bit p);
    tick = tk; link = ln; act = a; pd = p;
    @(negedge clk);
    cmp_model();
  endtask

  task automatic absent_ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'b000, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tx_en, 1'b1, "R1 tx_en in reset");
    chk(nlp_req, 1'b0, "R1 nlp_req in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(rx_en, 1'b1, "R1 rx_en after reset");
    chk(restart, 1'b0, "R1 link_restart after reset");

    // R2 exact timeout edge, idle cycles do not count
    absent_ticks(T_TICKS - 1);
    for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 3'b000, 1'b0);
    chk(tx_en, 1'b1, "R2 one tick short stays normal");
    absent_ticks(1);
    chk(tx_en, 1'b0, "R2 saving at timeout tick");

    // R4 link pulse pacing from entry
    absent_ticks(P_TICKS - 1);
    chk(nlp_req, 1'b0, "R4 no pulse before pace");
    absent_ticks(1);
    chk(nlp_req, 1'b1, "R4 pulse after pace tick");
    cyc(1'b0, 1'b0, 3'b000, 1'b0);
    chk(nlp_req, 1'b0, "R4 pulse lasts one cycle");

    // R5 each activity kind wakes alone
    for (int k = 0; k < 3; k++) begin
      cyc(1'b0, 1'b0, 3'b001 << k, 1'b0);
      chk(tx_en, 1'b1, "R5 wake on activity bit");
      absent_ticks(T_TICKS - 1);
      chk(tx_en, 1'b1, "R5 timeout restarts from zero");
      absent_ticks(1);
      chk(tx_en, 1'b0, "R5 saving again");
    end
    cyc(1'b0, 1'b0, 3'b100, 1'b0);

    // R3 reconnection clears the absence count
    absent_ticks(T_TICKS - 2);
    cyc(1'b0, 1'b1, 3'b000, 1'b0);
    absent_ticks(T_TICKS - 1);
    chk(tx_en, 1'b1, "R3 count cleared by reconnection");
    absent_ticks(1);
    chk(tx_en, 1'b0, "R3 full timeout after reconnection");

    // R6 power-down from saving, activity and ticks ignored
    cyc(1'b1, 1'b0, 3'b111, 1'b1);
    chk(tx_en, 1'b0, "R6 tx off in power-down");
    for (int i = 0; i < 2*P_TICKS; i++) begin
      cyc(1'b1, 1'b1, 3'b111, 1'b1);
      chk(nlp_req, 1'b0, "R6 no link pulse in power-down");
      chk(rx_en, 1'b0, "R6 rx off in power-down");
    end

    // R7 release restarts the link
    cyc(1'b0, 1'b0, 3'b000, 1'b0);
    chk(tx_en, 1'b1, "R7 normal after release");
    chk(restart, 1'b1, "R7 restart pulse");
    cyc(1'b0, 1'b0, 3'b000, 1'b0);
    chk(restart, 1'b0, "R7 restart one cycle");
    absent_ticks(T_TICKS - 1);
    chk(tx_en, 1'b1, "R7 timeout from zero after release");

    // Random phase
    begin
      bit ln = 1'b0, p = 1'b0;
      for (int i = 0; i < 6000; i++) begin
        logic [2:0] a;
        if ($urandom % 60 == 0)  ln = ~ln;
        if ($urandom % 400 == 0) p  = ~p;
        a[0] = ($urandom % 40 == 0);
        a[1] = ($urandom % 40 == 0);
        a[2] = ($urandom % 40 == 0);
        cyc(($urandom % 2) == 0, ln, a, p);
      end
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule